// File: doc/BRIEF.md
# Vector AES Encryption-Round Unit

This block runs one AES encryption round over a group of vector registers. The group holds two or four registers. Each register is up to 512 bits wide and is split into 128-bit segments. Each segment has its round key XORed in first. It then passes through ShiftRows, then SubBytes, then MixColumns. The key for a segment comes from a 128-bit lane of a separate key vector. A 2-bit key index picks that lane inside the 512-bit group the segment belongs to, and the active vector length trims the index.

The caller drives the state group, the key vector, the vector-length code, the group size and the key index, then pulses `start`. The unit takes a snapshot of every input. It works through one segment per clock, register by register and segment by segment, overwriting the snapshot in place. It then pulses `done`, and from that point `state_out` carries the updated group, ready to replace the source registers.

The controller has three states:
- `ST_IDLE`: waits for `start`. Taking `start` here loads the snapshot and moves to `ST_RUN`.
- `ST_RUN`: writes one segment per cycle. After the last segment of the last register it moves to `ST_DONE`.
- `ST_DONE`: raises `done` for one cycle and returns to `ST_IDLE` without a condition.

Top module: `avr_unit`

## Requirements
- R1: Each processed 128-bit segment becomes MixColumns(SubBytes(ShiftRows(segment XOR key))). Byte k of a segment sits at bits [8k+7:8k] and is row k mod 4, column k div 4.
- R2: SubBytes is the standard AES forward S-box. MixColumns multiplies each column by {02},{03},{01},{01} over GF(2^8) modulo 0x11B. An all-zero state with an all-zero key therefore gives 0x63 in every processed byte.
- R3: `grp4`=0 selects a group of registers 0 and 1, and `grp4`=1 selects registers 0 to 3. Register r occupies `state_out[512r+511:512r]`. Registers outside the group are returned unchanged.
- R4: `vl_sel` 0 means 128 bits, 1 means 256 bits, and 2 or 3 mean 512 bits. Each register has VL/128 segments, and segment s occupies bits [128s+127:128s] of its register. Bits above VL are returned unchanged.
- R5: Segment s uses key lane (s - s mod 4) + e, where lane j is `key_in[128j+127:128j]`. The effective index e is 0 at 128 bits, `key_idx` mod 2 at 256 bits, and `key_idx` at 512 bits.
- R6: One key index applies to every segment of every register in the group.
- R7: Results come only from the inputs sampled when `start` is accepted. Changes to `state_in` or `key_in` during a run have no effect.
- R8: `done` is a one-cycle pulse that appears exactly nreg*VL/128 + 1 clock edges after the edge that accepts `start`.
- R9: After reset, `busy`=0, `done`=0 and `state_out`=0.
- R10: `start` is accepted only while `busy` is low. A `start` during a run changes neither the result nor the timing, and produces no extra `done`.
- R11: While the unit is idle and `start` is low, `state_out` holds its value whatever `state_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| vl_sel | input | 2 | Vector length code (0:128, 1:256, 2/3:512) |
| grp4 | input | 1 | Group size: 0 = two registers, 1 = four |
| key_idx | input | 2 | Round key lane index |
| state_in | input | 2048 | Source register group, register r at [512r+511:512r] |
| key_in | input | 512 | Key vector |
| state_out | output | 2048 | Updated register group |
| busy | output | 1 | Operation in progress (run and done cycles) |
| done | output | 1 | One-cycle completion pulse |

## Verification
If a segment or register counter is wrong, whole 128-bit segments show the wrong value or stay untouched at `done`. The wrong segment count also shifts `done` away from nreg*VL/128 + 1 cycles, so the latency check catches it on the same operation. A wrong key-lane choice or a faulty transformation corrupts every byte of the segments it affects. That shows up at the first `done` after the fault. If snapshot or hold control breaks, `state_out` moves while the unit is idle, or a run accepts a `start` it should ignore. Either one appears within a cycle or two.

// File: rtl/avr_pkg.sv
package avr_pkg;
    localparam int SEG_BITS = 128;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} avr_state_e;
    typedef enum logic [1:0] {VL_128 = 2'd0, VL_256 = 2'd1, VL_512 = 2'd2, VL_512B = 2'd3} avr_vl_e;

    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] t;
        acc = 8'h00;
        t   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ t;
            t = gf_xtime(t);
        end
        return acc;
    endfunction

    // multiplicative inverse as x^254 (0 maps to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 7; i >= 0; i--) begin
            r = gf_mul(r, r);
            if (i != 0) r = gf_mul(r, x);
        end
        return r;
    endfunction

    function automatic logic [7:0] aes_sbox(input logic [7:0] x);
        logic [7:0] b;
        b = gf_inv(x);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction
endpackage

// File: rtl/avr_round.sv
module avr_round
    import avr_pkg::*;
(
    input  logic [SEG_BITS-1:0] seg_i,
    input  logic [SEG_BITS-1:0] key_i,
    output logic [SEG_BITS-1:0] seg_o
);
    logic [SEG_BITS-1:0] keyed;
    logic [SEG_BITS-1:0] shifted;
    logic [SEG_BITS-1:0] subbed;

    assign keyed = seg_i ^ key_i;

    always_comb begin
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                shifted[8*(4*c+r) +: 8] = keyed[8*(4*((c+r)%4)+r) +: 8];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < 16; k++) begin
            subbed[8*k +: 8] = aes_sbox(shifted[8*k +: 8]);
        end
    end

    always_comb begin
        for (int c = 0; c < 4; c++) begin
            logic [7:0] a0, a1, a2, a3;
            a0 = subbed[32*c +: 8];
            a1 = subbed[32*c+8 +: 8];
            a2 = subbed[32*c+16 +: 8];
            a3 = subbed[32*c+24 +: 8];
            seg_o[32*c +: 8]    = gf_xtime(a0) ^ gf_mul(a1, 8'h03) ^ a2 ^ a3;
            seg_o[32*c+8 +: 8]  = a0 ^ gf_xtime(a1) ^ gf_mul(a2, 8'h03) ^ a3;
            seg_o[32*c+16 +: 8] = a0 ^ a1 ^ gf_xtime(a2) ^ gf_mul(a3, 8'h03);
            seg_o[32*c+24 +: 8] = gf_mul(a0, 8'h03) ^ a1 ^ a2 ^ gf_xtime(a3);
        end
    end
endmodule

// File: rtl/avr_keysel.sv
module avr_keysel
    import avr_pkg::*;
#(
    parameter int VLEN_MAX = 512,
    localparam int SEGS  = VLEN_MAX / SEG_BITS,
    localparam int SEG_W = $clog2(SEGS)
) (
    input  logic [VLEN_MAX-1:0] key_vec_i,
    input  avr_vl_e             vl_i,
    input  logic [1:0]          idx_i,
    input  logic [SEG_W-1:0]    seg_i,
    output logic [SEG_BITS-1:0] key_o
);
    logic [1:0]       eff_idx;
    logic [SEG_W-1:0] lane;

    always_comb begin
        unique case (vl_i)
            VL_128:  eff_idx = 2'd0;
            VL_256:  eff_idx = {1'b0, idx_i[0]};
            default: eff_idx = idx_i;
        endcase
    end

    // lane = (s - s mod 4) + effective index
    generate
        if (SEG_W > 2) begin : g_wide
            assign lane = {seg_i[SEG_W-1:2], eff_idx};
        end else begin : g_single
            logic unused_seg;
            assign unused_seg = ^seg_i;
            assign lane = eff_idx;
        end
    endgenerate

    assign key_o = key_vec_i[{lane, 7'd0} +: SEG_BITS];
endmodule

// File: rtl/avr_seq.sv
module avr_seq
    import avr_pkg::*;
#(
    parameter int REG_W = 2,
    parameter int SEG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [REG_W-1:0] reg_last_i,
    input  logic [SEG_W-1:0] seg_last_i,
    output logic             load_o,
    output logic             wr_en_o,
    output logic [REG_W-1:0] reg_idx_o,
    output logic [SEG_W-1:0] seg_idx_o,
    output logic             busy_o,
    output logic             done_o
);
    avr_state_e state_q, state_d;
    logic       last_seg;

    assign last_seg = (seg_idx_o == seg_last_i) && (reg_idx_o == reg_last_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)  state_d = ST_RUN;
            ST_RUN:  if (last_seg) state_d = ST_DONE;
            ST_DONE:               state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o  = (state_q == ST_IDLE) && start_i;
        wr_en_o = (state_q == ST_RUN);
        busy_o  = (state_q != ST_IDLE);
        done_o  = (state_q == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_idx_o <= '0;
            seg_idx_o <= '0;
        end else if (load_o) begin
            reg_idx_o <= '0;
            seg_idx_o <= '0;
        end else if (wr_en_o && !last_seg) begin
            if (seg_idx_o == seg_last_i) begin
                seg_idx_o <= '0;
                reg_idx_o <= reg_idx_o + 1'b1;
            end else begin
                seg_idx_o <= seg_idx_o + 1'b1;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(wr_en_o)); // R8
    AST_SEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (seg_idx_o <= seg_last_i && reg_idx_o <= reg_last_i)); // R4
endmodule

// File: rtl/avr_unit.sv
module avr_unit
    import avr_pkg::*;
#(
    parameter int VLEN_MAX = 512,
    parameter int NREG_MAX = 4,
    localparam int SEGS  = VLEN_MAX / SEG_BITS,
    localparam int SEG_W = $clog2(SEGS),
    localparam int REG_W = $clog2(NREG_MAX),
    localparam int TOTAL = NREG_MAX * VLEN_MAX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          vl_sel,
    input  logic                grp4,
    input  logic [1:0]          key_idx,
    input  logic [TOTAL-1:0]    state_in,
    input  logic [VLEN_MAX-1:0] key_in,
    output logic [TOTAL-1:0]    state_out,
    output logic                busy,
    output logic                done
);
    logic [TOTAL-1:0]    work_q;
    logic [VLEN_MAX-1:0] key_q;
    avr_vl_e             vl_q;
    logic                grp_q;
    logic [1:0]          idx_q;

    logic                load, wr_en;
    logic [REG_W-1:0]    reg_idx, reg_last;
    logic [SEG_W-1:0]    seg_idx, seg_last;
    logic [SEG_BITS-1:0] seg_cur, key_seg, seg_new;

    always_comb begin
        unique case (vl_q)
            VL_128:  seg_last = SEG_W'(0);
            VL_256:  seg_last = SEG_W'(1);
            default: seg_last = SEG_W'(SEGS - 1);
        endcase
    end
    assign reg_last = grp_q ? REG_W'(NREG_MAX - 1) : REG_W'(1);

    avr_seq #(.REG_W(REG_W), .SEG_W(SEG_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .reg_last_i (reg_last),
        .seg_last_i (seg_last),
        .load_o     (load),
        .wr_en_o    (wr_en),
        .reg_idx_o  (reg_idx),
        .seg_idx_o  (seg_idx),
        .busy_o     (busy),
        .done_o     (done)
    );

    avr_keysel #(.VLEN_MAX(VLEN_MAX)) u_keysel (
        .key_vec_i (key_q),
        .vl_i      (vl_q),
        .idx_i     (idx_q),
        .seg_i     (seg_idx),
        .key_o     (key_seg)
    );

    assign seg_cur = work_q[{reg_idx, seg_idx, 7'd0} +: SEG_BITS];

    avr_round u_round (
        .seg_i (seg_cur),
        .key_i (key_seg),
        .seg_o (seg_new)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
            key_q  <= '0;
            vl_q   <= VL_128;
            grp_q  <= 1'b0;
            idx_q  <= 2'd0;
        end else if (load) begin
            work_q <= state_in;
            key_q  <= key_in;
            vl_q   <= avr_vl_e'(vl_sel);
            grp_q  <= grp4;
            idx_q  <= key_idx;
        end else if (wr_en) begin
            work_q[{reg_idx, seg_idx, 7'd0} +: SEG_BITS] <= seg_new;
        end
    end

    assign state_out = work_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(state_out)); // R11
    AST_KEY_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && vl_q == VL_128) |-> (key_seg == key_q[SEG_BITS-1:0])); // R5
    AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(key_q)); // R10
endmodule

// File: tb/test_avr_unit.sv
`timescale 1ns/1ps
module test_avr_unit;
    localparam int TOT = 2048;
    localparam int VW  = 512;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [1:0]     vl_sel = 2'd0;
    logic           grp4 = 1'b0;
    logic [1:0]     key_idx = 2'd0;
    logic [TOT-1:0] state_in = '0;
    logic [VW-1:0]  key_in = '0;
    logic [TOT-1:0] state_out;
    logic           busy, done;

    int checks = 0;
    int errors = 0;

    logic [TOT-1:0] exp_q[$];
    string          tag_q[$];
    logic [TOT-1:0] last_exp = '0;
    logic [7:0]     sb [256];

    always #4 clk = ~clk;

    avr_unit i_avr_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_sel(vl_sel), .grp4(grp4),
        .key_idx(key_idx), .state_in(state_in), .key_in(key_in),
        .state_out(state_out), .busy(busy), .done(done)
    );

    task automatic build_sbox();
        logic [7:0] p, q, x;
        p = 8'h01; q = 8'h01;
        do begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b0};
            q = q ^ {q[3:0], 4'b0};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]} ^ 8'h63;
            sb[p] = x;
        end while (p != 8'h01);
        sb[0] = 8'h63;
    endtask

    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    // reference round: key add, row shift, byte substitution, column mix (R1, R2)
    function automatic logic [127:0] ref_round(input logic [127:0] s, input logic [127:0] k);
        logic [7:0] b [16];
        logic [7:0] t [16];
        logic [127:0] o;
        for (int i = 0; i < 16; i++) b[i] = s[8*i +: 8] ^ k[8*i +: 8];
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) t[4*c+r] = sb[b[4*((c+r)%4)+r]];
        for (int c = 0; c < 4; c++) begin
            logic [7:0] a0, a1, a2, a3;
            a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
            o[32*c +: 8]    = xt(a0) ^ (xt(a1) ^ a1) ^ a2 ^ a3;
            o[32*c+8 +: 8]  = a0 ^ xt(a1) ^ (xt(a2) ^ a2) ^ a3;
            o[32*c+16 +: 8] = a0 ^ a1 ^ xt(a2) ^ (xt(a3) ^ a3);
            o[32*c+24 +: 8] = (xt(a0) ^ a0) ^ a1 ^ a2 ^ xt(a3);
        end
        return o;
    endfunction

    function automatic int nseg_of(input logic [1:0] vl);
        return (vl == 2'd0) ? 1 : (vl == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [TOT-1:0] ref_op(input logic [TOT-1:0] st, input logic [VW-1:0] key,
                                              input logic [1:0] vl, input logic g4, input logic [1:0] idx);
        logic [TOT-1:0] r;
        int nreg, nseg, eff, lane;
        r = st;
        nreg = g4 ? 4 : 2;
        nseg = nseg_of(vl);
        eff = (vl == 2'd0) ? 0 : (vl == 2'd1) ? int'(idx % 2) : int'(idx);
        for (int g = 0; g < nreg; g++)
            for (int s = 0; s < nseg; s++) begin
                lane = (s - (s % 4)) + eff;
                r[g*512 + s*128 +: 128] = ref_round(st[g*512 + s*128 +: 128], key[lane*128 +: 128]);
            end
        return r;
    endfunction

    function automatic logic [TOT-1:0] rnd_vec();
        logic [TOT-1:0] v;
        for (int i = 0; i < TOT/32; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input bit ok, input string what, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // monitor: compares each completion against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 R10 unexpected done", {2047'b0, done}, '0);
            end else begin
                logic [TOT-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(state_out === e, t, state_out, e);
            end
        end
    end

    // driver: pushes the expectation, starts the operation, measures latency
    task automatic run_op(input logic [TOT-1:0] st, input logic [VW-1:0] key, input logic [1:0] vl,
                          input logic g4, input logic [1:0] idx, input string tag, input bit disturb);
        logic [TOT-1:0] e;
        int cnt, lat;
        e = ref_op(st, key, vl, g4, idx);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_exp = e;
        lat = (g4 ? 4 : 2) * nseg_of(vl) + 1;
        @(negedge clk);
        state_in = st; key_in = key; vl_sel = vl; grp4 = g4; key_idx = idx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 100) begin
            if (disturb && cnt == 2) begin
                state_in = rnd_vec(); key_in = rnd_vec(); key_idx = ~idx; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        check(cnt == lat, "R8 done latency", TOT'(cnt), TOT'(lat));
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [VW-1:0]  k;
        logic [TOT-1:0] held;
        build_sbox();
        repeat (3) @(negedge clk);
        // R9 reset state
        check(state_out === '0, "R9 reset state_out", state_out, '0);
        check(busy === 1'b0, "R9 reset busy", {2047'b0, busy}, '0);
        check(done === 1'b0, "R9 reset done", {2047'b0, done}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 known case: zero state, zero key, full width -> 0x63 everywhere
        run_op('0, '0, 2'd2, 1'b1, 2'd0, "R2 zero state zero key", 1'b0);
        check(state_out === {256{8'h63}}, "R2 uniform 0x63", state_out, {256{8'h63}});

        // R1 R3 R4 R5 R6: every length and group size, several indices
        for (int v = 0; v < 4; v++)
            for (int g = 0; g < 2; g++)
                for (int x = 0; x < 4; x += (v == 0 ? 3 : 1))
                    run_op(rnd_vec(), rnd_vec(), 2'(v), 1'(g), 2'(x), "R1 R3 R4 R5 R6 round result", 1'b0);

        // R5 distinct key lanes, 256-bit length, index 3 folds to lane 1
        k = {128'h33333333_33333333_33333333_33333333, 128'h22222222_22222222_22222222_22222222,
             128'h11111111_11111111_11111111_11111111, 128'h00010203_04050607_08090a0b_0c0d0e0f};
        run_op('0, k, 2'd1, 1'b0, 2'd3, "R5 index folding at 256", 1'b0);

        // R7 R10: inputs change and start pulses during the run
        run_op(rnd_vec(), rnd_vec(), 2'd2, 1'b1, 2'd2, "R7 R10 snapshot and ignored start", 1'b1);

        // R11 idle hold with changing inputs
        held = state_out;
        state_in = rnd_vec(); key_in = rnd_vec();
        repeat (5) @(negedge clk);
        check(state_out === held && held === last_exp, "R11 idle hold", state_out, last_exp);
        check(exp_q.size() == 0, "R8 all results seen", TOT'(exp_q.size()), '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule